// File: doc/BRIEF.md
# Prioritized Local Interrupt Selector

This block decides which pending local interrupt a hart should take next. Each cycle it forms the candidate set from the pending and enable vectors. It then applies privilege-dependent global enables. Candidates that are delegated to supervisor level are gated differently from those that stay at machine level. The lowest-numbered survivor wins. The choice, its cause index and a flag are registered and presented one cycle later. The flag says the trap must be forced to the hypervisor-supervisor level.

When the hart runs a virtualized guest, selection has two tiers. The three virtual-supervisor bits (software, timer and external) are held apart from every other candidate. The other candidates are screened first against the hypervisor-level supervisor enable. If any of them survives, it wins and the force flag is raised. Only when none survives do the virtual-supervisor bits go through the normal delegation gating. Trap entry, register access and external interrupt routing belong to neighbouring logic.

Top module: `irq_pick_top`

## Requirements
- R1: The candidate set is `pend_i & en_i`. A bit that is pending but not enabled is never selected. A reported cause is always a bit that was a candidate in the sampled cycle.
- R2: Privilege is encoded as 0 = user, 1 = supervisor, 3 = machine. Value 2 is reserved: it counts as below machine and is not supervisor. Non-delegated candidates pass when privilege is below machine, or when privilege is machine and `m_gie_i` is 1.
- R3: Delegated candidates pass when privilege is user, or when privilege is supervisor and `s_gie_i` is 1. At machine privilege a delegated candidate never passes.
- R4: A candidate with its `deleg_i` bit at 0 is gated only by the machine-level enable of R2. A candidate with its `deleg_i` bit at 1 is gated only by the supervisor-level enable of R3.
- R5: Among the surviving candidates of one tier, the lowest bit index is reported as the cause.
- R6: Bits 2, 6 and 10 are the virtual-supervisor software, timer and external bits. With `virt_on_i` at 0 they are never selected, whatever the enables and delegation.
- R7: With `virt_on_i` at 1, every candidate other than bits 2, 6 and 10 is first gated by the hypervisor-level enable. That enable passes when privilege is user, or when privilege is supervisor and `hs_sie_i` is 1. If any candidate survives, the lowest one is taken and `to_hs_o` is 1. This holds even when a lower virtual-supervisor bit is also eligible.
- R8: With `virt_on_i` at 1 and no survivor in the first tier, only bits 2, 6 and 10 are considered, through the gating of R4. `to_hs_o` is then 0.
- R9: With `virt_on_i` at 0, `to_hs_o` is 0.
- R10: Outputs are registered. They reflect the inputs sampled at the previous rising edge and are unchanged between edges. Synchronous active-low reset, and the case where nothing survives, both give `take_o` = 0, `cause_o` = 0 and `to_hs_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | 64 | Pending interrupt vector |
| en_i | input | 64 | Interrupt enable vector |
| deleg_i | input | 64 | Delegation mask, 1 = handled at supervisor level |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| virt_on_i | input | 1 | Hart runs a virtualized guest |
| hs_sie_i | input | 1 | Hypervisor-level supervisor interrupt enable |
| take_o | output | 1 | An interrupt should be taken |
| cause_o | output | 6 | Index of the selected interrupt |
| to_hs_o | output | 1 | Force the trap to the hypervisor-supervisor level |

## Verification
The hardest situation to reach is the tier hand-off under virtualization. A candidate outside the virtual-supervisor set must be present, yet be suppressed only by the hypervisor-level enable. At the same time a lower virtual-supervisor bit must survive the delegation gating. The directed tests build both sides of that boundary at supervisor privilege by flipping only `hs_sie_i`. The two runs show that the same pending pattern yields a forced higher index in one case and an unforced virtual bit in the other.

// File: rtl/irq_pick_pkg.sv
// Package irq_pick_pkg
// Shared privilege encoding and fixed bit positions for the interrupt
// selector. Assumes a 2-bit privilege code; value 2 is reserved.
package irq_pick_pkg;

    typedef enum logic [1:0] {
        LVL_USER = 2'd0,
        LVL_SUPV = 2'd1,
        LVL_RSVD = 2'd2,
        LVL_MACH = 2'd3
    } lvl_e;

    // Virtual-supervisor software, timer and external bit positions.
    localparam int GUEST_SW_BIT  = 2;
    localparam int GUEST_TMR_BIT = 6;
    localparam int GUEST_EXT_BIT = 10;

endpackage

// File: rtl/irq_pick_gate.sv
// Module irq_pick_gate
// Turns the current privilege and the three global enable bits into
// per-level pass signals. Purely combinational; assumes the privilege
// encoding of irq_pick_pkg.
module irq_pick_gate
    import irq_pick_pkg::*;
(
    input  logic [1:0] priv_i,
    input  logic       m_gie_i,
    input  logic       s_gie_i,
    input  logic       hs_sie_i,
    output logic       m_pass_o,
    output logic       s_pass_o,
    output logic       hs_pass_o
);

    logic below_m;
    logic below_s;
    logic at_m;
    logic at_s;

    // Compare privilege against the machine and supervisor levels.
    always_comb begin
        below_m = (priv_i < 2'(LVL_MACH));
        below_s = (priv_i < 2'(LVL_SUPV));
        at_m    = (priv_i == 2'(LVL_MACH));
        at_s    = (priv_i == 2'(LVL_SUPV));
    end

    // Combine level comparisons with the global enables.
    always_comb begin
        m_pass_o  = below_m || (at_m && m_gie_i);
        s_pass_o  = below_s || (at_s && s_gie_i);
        hs_pass_o = below_s || (at_s && hs_sie_i);
    end

endmodule

// File: rtl/irq_pick_ctz.sv
// Module irq_pick_ctz
// Finds the lowest set bit of a vector (trailing-zero count). Reports
// whether any bit is set; index is 0 when none is.
module irq_pick_ctz #(
    parameter int VEC_W = 64,
    localparam int IDX_W = $clog2(VEC_W)
) (
    input  logic [VEC_W-1:0] vec_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        idx_o = '0;
        for (int i = VEC_W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

    // Any bit set at all.
    always_comb begin
        any_o = |vec_i;
    end

endmodule

// File: rtl/irq_pick_top.sv
// Module irq_pick_top
// Selects the local interrupt a hart should take. Builds the two
// selection tiers and applies delegation gating. Registers the winning
// cause, the take strobe and the force-to-hypervisor flag. Assumes
// IRQ_W > 10 so that the guest bits exist.
module irq_pick_top
    import irq_pick_pkg::*;
#(
    parameter int IRQ_W = 64,
    localparam int CAUSE_W = $clog2(IRQ_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IRQ_W-1:0]   pend_i,
    input  logic [IRQ_W-1:0]   en_i,
    input  logic [IRQ_W-1:0]   deleg_i,
    input  logic [1:0]         priv_i,
    input  logic               m_gie_i,
    input  logic               s_gie_i,
    input  logic               virt_on_i,
    input  logic               hs_sie_i,
    output logic               take_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               to_hs_o
);

    localparam logic [IRQ_W-1:0] GUEST_MASK =
        (IRQ_W'(1) << GUEST_SW_BIT) |
        (IRQ_W'(1) << GUEST_TMR_BIT) |
        (IRQ_W'(1) << GUEST_EXT_BIT);

    logic               m_pass;
    logic               s_pass;
    logic               hs_pass;
    logic [IRQ_W-1:0]   cand;
    logic [IRQ_W-1:0]   host_cand;
    logic [IRQ_W-1:0]   guest_cand;
    logic [IRQ_W-1:0]   tier1_vec;
    logic [IRQ_W-1:0]   tier2_src;
    logic [IRQ_W-1:0]   tier2_vec;
    logic               tier1_any;
    logic               tier2_any;
    logic [CAUSE_W-1:0] tier1_idx;
    logic [CAUSE_W-1:0] tier2_idx;
    logic               take_d;
    logic [CAUSE_W-1:0] cause_d;
    logic               to_hs_d;

    irq_pick_gate u_gate (
        .priv_i    (priv_i),
        .m_gie_i   (m_gie_i),
        .s_gie_i   (s_gie_i),
        .hs_sie_i  (hs_sie_i),
        .m_pass_o  (m_pass),
        .s_pass_o  (s_pass),
        .hs_pass_o (hs_pass)
    );

    // Form candidates and split out the guest bits.
    always_comb begin
        cand       = pend_i & en_i;
        host_cand  = cand & ~GUEST_MASK;
        guest_cand = cand & GUEST_MASK;
    end

    // First tier: host candidates under the hypervisor-level enable.
    always_comb begin
        tier1_vec = (virt_on_i && hs_pass) ? host_cand : '0;
    end

    // Second tier: delegation split on the set chosen by virtualization.
    always_comb begin
        tier2_src = virt_on_i ? guest_cand : host_cand;
        tier2_vec = (tier2_src & ~deleg_i & {IRQ_W{m_pass}}) |
                    (tier2_src &  deleg_i & {IRQ_W{s_pass}});
    end

    irq_pick_ctz #(.VEC_W(IRQ_W)) u_ctz_tier1 (
        .vec_i (tier1_vec),
        .any_o (tier1_any),
        .idx_o (tier1_idx)
    );

    irq_pick_ctz #(.VEC_W(IRQ_W)) u_ctz_tier2 (
        .vec_i (tier2_vec),
        .any_o (tier2_any),
        .idx_o (tier2_idx)
    );

    // Pick the tier result; the first tier has precedence.
    always_comb begin
        take_d  = tier1_any || tier2_any;
        to_hs_d = tier1_any;
        cause_d = tier1_any ? tier1_idx : (tier2_any ? tier2_idx : '0);
    end

    // Register the decision; reset reports no interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o  <= 1'b0;
            cause_o <= '0;
            to_hs_o <= 1'b0;
        end else begin
            take_o  <= take_d;
            cause_o <= cause_d;
            to_hs_o <= to_hs_d;
        end
    end

    // R1: a reported cause was a candidate one cycle earlier.
    p_cause_was_cand_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ((($past(pend_i & en_i)) >> cause_o) & IRQ_W'(1)) != '0);

    // R1: nothing enabled and pending gives no take next cycle.
    p_idle_no_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & en_i) == '0) |=> !take_o);

    // R6: guest bits are never chosen with virtualization off.
    p_guest_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !virt_on_i |=> !(take_o && ((GUEST_MASK >> cause_o) & IRQ_W'(1)) != '0));

    // R9: no forcing with virtualization off.
    p_force_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !virt_on_i |=> !to_hs_o);

    // R7: forcing always comes with a take and a non-guest cause.
    p_force_host_r7: assert property (@(posedge clk) disable iff (!rst_n)
        to_hs_o |-> (take_o && ((GUEST_MASK >> cause_o) & IRQ_W'(1)) == '0));

    // R10: no take means a zero cause.
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (cause_o == '0));

endmodule

// File: tb/irq_pick_top_test.sv
`timescale 1ns/1ps
module irq_pick_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] pend_i = '0;
    logic [63:0] en_i = '0;
    logic [63:0] deleg_i = '0;
    logic [1:0]  priv_i = 2'd0;
    logic        m_gie_i = 1'b0;
    logic        s_gie_i = 1'b0;
    logic        virt_on_i = 1'b0;
    logic        hs_sie_i = 1'b0;
    logic        take_o;
    logic [5:0]  cause_o;
    logic        to_hs_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_pick_top uut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i),
        .deleg_i(deleg_i), .priv_i(priv_i), .m_gie_i(m_gie_i),
        .s_gie_i(s_gie_i), .virt_on_i(virt_on_i), .hs_sie_i(hs_sie_i),
        .take_o(take_o), .cause_o(cause_o), .to_hs_o(to_hs_o)
    );

    function automatic logic [63:0] b(input int i);
        return 64'd1 << i;
    endfunction

    // Compare outputs with expected values.
    task automatic expect_out(input string req, input logic t, input logic [5:0] c, input logic h);
        checks++;
        if (take_o !== t || cause_o !== c || to_hs_o !== h) begin
            errors++;
            $display("FAIL %s: got take=%0d cause=%0d hs=%0d, expected take=%0d cause=%0d hs=%0d",
                     req, take_o, cause_o, to_hs_o, t, c, h);
        end
    endtask

    // Drive inputs away from the edge, wait one edge, then sample.
    task automatic apply(input logic [63:0] p, input logic [63:0] e, input logic [63:0] d,
                         input logic [1:0] pr, input logic mg, input logic sg,
                         input logic v, input logic hs);
        @(negedge clk);
        pend_i = p; en_i = e; deleg_i = d; priv_i = pr;
        m_gie_i = mg; s_gie_i = sg; virt_on_i = v; hs_sie_i = hs;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        expect_out("R10 reset", 1'b0, 6'd0, 1'b0);
    endtask

    task automatic t_mask();
        apply(b(5), 64'd0, 64'd0, 2'd0, 0, 0, 0, 0);
        expect_out("R1 not enabled", 1'b0, 6'd0, 1'b0);
        apply(b(5), b(5), 64'd0, 2'd0, 0, 0, 0, 0);
        expect_out("R1 enabled", 1'b1, 6'd5, 1'b0);
    endtask

    task automatic t_menable();
        apply(b(7), b(7), 64'd0, 2'd3, 0, 1, 0, 0);
        expect_out("R2 machine mie off", 1'b0, 6'd0, 1'b0);
        apply(b(7), b(7), 64'd0, 2'd3, 1, 0, 0, 0);
        expect_out("R2 machine mie on", 1'b1, 6'd7, 1'b0);
        apply(b(7), b(7), 64'd0, 2'd1, 0, 0, 0, 0);
        expect_out("R2 below machine", 1'b1, 6'd7, 1'b0);
    endtask

    task automatic t_senable();
        apply(b(9), b(9), b(9), 2'd1, 1, 0, 0, 0);
        expect_out("R3 supervisor sie off", 1'b0, 6'd0, 1'b0);
        apply(b(9), b(9), b(9), 2'd1, 0, 1, 0, 0);
        expect_out("R3 supervisor sie on", 1'b1, 6'd9, 1'b0);
        apply(b(9), b(9), b(9), 2'd0, 0, 0, 0, 0);
        expect_out("R3 user", 1'b1, 6'd9, 1'b0);
        apply(b(9), b(9), b(9), 2'd3, 1, 1, 0, 0);
        expect_out("R3 machine blocks delegated", 1'b0, 6'd0, 1'b0);
    endtask

    task automatic t_deleg();
        apply(b(1) | b(11), b(1) | b(11), b(1), 2'd1, 0, 0, 0, 0);
        expect_out("R4 split", 1'b1, 6'd11, 1'b0);
    endtask

    task automatic t_prio();
        apply(b(3) | b(13) | b(40), b(3) | b(13) | b(40), 64'd0, 2'd0, 0, 0, 0, 0);
        expect_out("R5 lowest", 1'b1, 6'd3, 1'b0);
        apply(b(63), b(63), 64'd0, 2'd0, 0, 0, 0, 0);
        expect_out("R5 top bit", 1'b1, 6'd63, 1'b0);
        apply(b(0) | b(63), b(0) | b(63), 64'd0, 2'd0, 0, 0, 0, 0);
        expect_out("R5 bit zero", 1'b1, 6'd0, 1'b0);
    endtask

    task automatic t_guest_off();
        apply(b(2) | b(6) | b(10), b(2) | b(6) | b(10), 64'd0, 2'd0, 1, 1, 0, 1);
        expect_out("R6 guest bits ignored", 1'b0, 6'd0, 1'b0);
        apply(b(2) | b(12), b(2) | b(12), 64'd0, 2'd0, 1, 1, 0, 1);
        expect_out("R9 no force", 1'b1, 6'd12, 1'b0);
    endtask

    task automatic t_virt();
        apply(b(2) | b(12), b(2) | b(12), 64'd0, 2'd0, 0, 0, 1, 0);
        expect_out("R7 host tier first", 1'b1, 6'd12, 1'b1);
        apply(b(6) | b(12), b(6) | b(12), b(6), 2'd1, 0, 1, 1, 1);
        expect_out("R7 host over lower guest", 1'b1, 6'd12, 1'b1);
        apply(b(6) | b(12), b(6) | b(12), b(6), 2'd1, 0, 1, 1, 0);
        expect_out("R8 guest tier", 1'b1, 6'd6, 1'b0);
        apply(b(6) | b(12), b(6) | b(12), b(6), 2'd1, 1, 0, 1, 0);
        expect_out("R8 guest delegated blocked", 1'b0, 6'd0, 1'b0);
    endtask

    task automatic t_latency();
        apply(b(20), b(20), 64'd0, 2'd0, 0, 0, 0, 0);
        expect_out("R10 first value", 1'b1, 6'd20, 1'b0);
        @(negedge clk);
        pend_i = b(21); en_i = b(21);
        #1;
        expect_out("R10 held between edges", 1'b1, 6'd20, 1'b0);
        @(posedge clk);
        #1;
        expect_out("R10 next edge", 1'b1, 6'd21, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_mask();
        t_menable();
        t_senable();
        t_deleg();
        t_prio();
        t_guest_off();
        t_virt();
        t_latency();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule